// File: doc/BRIEF.md
# Dual-Rate Memory Bus Arbiter with Opportunistic CPU Access

This block decides who owns a memory-side bus that is clocked at twice the rate of a system bus. Two parties contend for it: the CPU, and a bridge that forwards system-bus transactions through buffers. Each party carries a 2-bit priority, so there are four levels. A higher level wins outright. At an equal level, ownership alternates between the two sides. When both buses are quiet, the CPU is served without any contest.

Because the bridge buffers traffic, the system bus can still be busy while the memory-side bus sits idle. In that window the CPU may take an opportunistic "sneak" grant. Three conditions apply. The enable bit for the highest current or pending system-bus priority must be set. The CPU address must fall in the DDR window. The bridge must have nothing ready to issue. A sneak grant is flagged on its own output, and it does not affect the alternation turn.

The request/grant pair behaves like a valid/ready handshake with back-pressure, held for the length of the transfer. A requester keeps `cpu_req` or `brg_valid` asserted until it sees its grant. A grant stays high until the owner pulses its done strobe. The bus then returns to idle for one cycle, and arbitration runs again. A pending system-bus transaction is reported on `sys_active` from the moment its master asks for the system bus. `sys_prio` carries the highest priority among the current and pending system-bus transactions.

Top module: `dual_rate_arbiter`

## Requirements
- R1: When no grant is held and `cpu_req` is high while `sys_active` and `brg_valid` are both low, `gnt_cpu` rises at the next clock edge with `gnt_sneak` low.
- R2: When no grant is held, `cpu_req` is high, and `cpu_prio` is numerically greater than `sys_prio` (3 is highest) with `sys_active` or `brg_valid` high, the CPU receives a normal grant (`gnt_cpu` high, `gnt_sneak` low) at the next edge.
- R3: When no grant is held, both sides request, and `cpu_prio` is less than `sys_prio`, `gnt_brg` rises at the next edge.
- R4: When both sides request at equal priority, the grants alternate between them. The first equal-priority contest after reset goes to the bridge.
- R5: `gnt_cpu` and `gnt_brg` are never high together. A grant holds until its owner's done strobe is sampled high, then drops at that edge. The bus then stays idle for at least one cycle before the next grant.
- R6: A sneak grant (`gnt_cpu` and `gnt_sneak` both high) is issued in the following case. No grant is held. `cpu_req` and `sys_active` are high and `brg_valid` is low. The CPU does not win on priority. Bit `sys_prio` of the enable register is 1. `cpu_addr` lies in the DDR window.
- R7: A sneak grant is not issued when bit `sys_prio` of the enable register is 0.
- R8: A sneak grant is not issued when `(cpu_addr & DDR_MASK) != DDR_BASE`.
- R9: A sneak grant neither flips nor consumes the alternation turn.
- R10: The enable register resets to 4'b0000. On a clock edge where `cfg_we` is high, it loads `cfg_wdata`, with bit n enabling sneak grants at priority level n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory-side bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU request, held until granted |
| cpu_prio | input | 2 | CPU priority level |
| cpu_addr | input | AW | CPU target address |
| cpu_done | input | 1 | CPU transfer complete strobe |
| sys_active | input | 1 | A system-bus transaction is current or pending |
| sys_prio | input | 2 | Highest current or pending system-bus priority |
| brg_valid | input | 1 | Bridge has a transaction ready to issue |
| brg_done | input | 1 | Bridge transfer complete strobe |
| cfg_we | input | 1 | Write strobe for the sneak enable register |
| cfg_wdata | input | 4 | Sneak enable value, one bit per level |
| gnt_cpu | output | 1 | CPU owns the memory-side bus |
| gnt_brg | output | 1 | Bridge owns the memory-side bus |
| gnt_sneak | output | 1 | Current CPU grant is a sneak grant |

## Verification
The bench builds the arbiter with a 16-bit address, `DDR_MASK` = 16'hC000 and `DDR_BASE` = 16'h4000. With these values, one high address bit is enough to move the CPU in or out of the DDR window. Writing the enable register to 4'b0101 splits the four levels into permitted and refused sneak levels. A single vector walk can therefore reach all of the following: an allowed sneak, a sneak refused by its level, a sneak refused by its address, and the turn position after a sneak.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int PRIO_W = 2;
  localparam int LEVELS = 1 << PRIO_W;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_BRG  = 2'd2
  } owner_e;
endpackage

// File: rtl/arb_sneak_en.sv
module arb_sneak_en #(
  parameter int LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LEVELS-1:0] wdata,
  output logic [LEVELS-1:0] en
);
  always_ff @(posedge clk) begin
    if (!rst_n)  en <= '0;
    else if (we) en <= wdata;
  end
endmodule

// File: rtl/arb_sneak_qual.sv
module arb_sneak_qual #(
  parameter int          AW       = 32,
  parameter int          PRIO_W   = 2,
  parameter int          LEVELS   = 4,
  parameter logic [AW-1:0] DDR_BASE = '0,
  parameter logic [AW-1:0] DDR_MASK = '0
) (
  input  logic [LEVELS-1:0] en,
  input  logic [PRIO_W-1:0] sys_prio,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              mem_idle,
  input  logic              brg_valid,
  input  logic              sys_active,
  output logic              ok
);
  logic ddr_hit;
  logic level_on;

  assign ddr_hit  = (cpu_addr & DDR_MASK) == DDR_BASE;
  assign level_on = en[sys_prio];
  assign ok       = mem_idle && !brg_valid && sys_active && ddr_hit && level_on;
endmodule

// File: rtl/arb_turn.sv
module arb_turn (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  output logic turn_cpu
);
  always_ff @(posedge clk) begin
    if (!rst_n)      turn_cpu <= 1'b0;
    else if (toggle) turn_cpu <= !turn_cpu;
  end
endmodule

// File: rtl/dual_rate_arbiter.sv
module dual_rate_arbiter #(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] DDR_BASE = '0,
  parameter logic [AW-1:0] DDR_MASK = {2'b11, {(AW-2){1'b0}}}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_req,
  input  logic [arb_pkg::PRIO_W-1:0]  cpu_prio,
  input  logic [AW-1:0]               cpu_addr,
  input  logic                        cpu_done,
  input  logic                        sys_active,
  input  logic [arb_pkg::PRIO_W-1:0]  sys_prio,
  input  logic                        brg_valid,
  input  logic                        brg_done,
  input  logic                        cfg_we,
  input  logic [arb_pkg::LEVELS-1:0]  cfg_wdata,
  output logic                        gnt_cpu,
  output logic                        gnt_brg,
  output logic                        gnt_sneak
);
  import arb_pkg::*;

  owner_e              own_q;
  logic                sneak_q;
  logic [LEVELS-1:0]   en;
  logic                turn_cpu;
  logic                sneak_ok;
  logic                mem_idle;
  logic                contested;
  logic                prio_eq;
  logic                cpu_wins;
  logic                pick_cpu, pick_brg, pick_snk, tog;

  assign mem_idle  = (own_q == OWN_NONE);
  assign contested = sys_active || brg_valid;
  assign prio_eq   = (cpu_prio == sys_prio);
  assign cpu_wins  = (cpu_prio > sys_prio) || (prio_eq && turn_cpu);

  arb_sneak_en #(.LEVELS(LEVELS)) u_en (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .en(en)
  );

  arb_sneak_qual #(
    .AW(AW), .PRIO_W(PRIO_W), .LEVELS(LEVELS),
    .DDR_BASE(DDR_BASE), .DDR_MASK(DDR_MASK)
  ) u_qual (
    .en(en), .sys_prio(sys_prio), .cpu_addr(cpu_addr), .mem_idle(mem_idle),
    .brg_valid(brg_valid), .sys_active(sys_active), .ok(sneak_ok)
  );

  arb_turn u_turn (
    .clk(clk), .rst_n(rst_n), .toggle(tog), .turn_cpu(turn_cpu)
  );

  // Decision made only while the memory-side bus is idle.
  always_comb begin
    pick_cpu = 1'b0;
    pick_brg = 1'b0;
    pick_snk = 1'b0;
    tog      = 1'b0;
    if (mem_idle) begin
      if (cpu_req && !contested) begin
        pick_cpu = 1'b1;
      end else if (cpu_req && cpu_wins) begin
        pick_cpu = 1'b1;
        tog      = prio_eq;
      end else if (brg_valid) begin
        pick_brg = 1'b1;
        tog      = cpu_req && prio_eq;
      end else if (cpu_req && sneak_ok) begin
        pick_cpu = 1'b1;
        pick_snk = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q   <= OWN_NONE;
      sneak_q <= 1'b0;
    end else if (mem_idle) begin
      if (pick_cpu)      own_q <= OWN_CPU;
      else if (pick_brg) own_q <= OWN_BRG;
      sneak_q <= pick_snk;
    end else if ((own_q == OWN_CPU && cpu_done) || (own_q == OWN_BRG && brg_done)) begin
      own_q   <= OWN_NONE;
      sneak_q <= 1'b0;
    end
  end

  assign gnt_cpu   = (own_q == OWN_CPU);
  assign gnt_brg   = (own_q == OWN_BRG);
  assign gnt_sneak = sneak_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] DDR_BASE = '0,
  parameter logic [AW-1:0] DDR_MASK = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic [1:0]    cpu_prio,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_done,
  input logic          sys_active,
  input logic [1:0]    sys_prio,
  input logic          brg_valid,
  input logic          brg_done,
  input logic          gnt_cpu,
  input logic          gnt_brg,
  input logic          gnt_sneak
);
  logic idle;
  assign idle = !gnt_cpu && !gnt_brg;

  assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_cpu, gnt_brg}));
  assert_hold_cpu_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_cpu && !cpu_done |=> gnt_cpu);
  assert_hold_brg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_brg && !brg_done |=> gnt_brg);
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_cpu && cpu_done) || (gnt_brg && brg_done) |=> idle);
  assert_idle_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle && cpu_req && !sys_active && !brg_valid |=> gnt_cpu && !gnt_sneak);
  assert_high_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idle && cpu_req && (cpu_prio > sys_prio) |=> gnt_cpu && !gnt_sneak);
  assert_low_loses_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idle && cpu_req && brg_valid && (cpu_prio < sys_prio) |=> gnt_brg);
  assert_sneak_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_sneak |-> gnt_cpu);
  assert_sneak_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_sneak) |-> $past(sys_active && !brg_valid));
  assert_sneak_ddr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_sneak) |-> (($past(cpu_addr) & DDR_MASK) == DDR_BASE));
endmodule

bind dual_rate_arbiter arb_checker #(
  .AW(AW), .DDR_BASE(DDR_BASE), .DDR_MASK(DDR_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_prio(cpu_prio),
  .cpu_addr(cpu_addr), .cpu_done(cpu_done), .sys_active(sys_active),
  .sys_prio(sys_prio), .brg_valid(brg_valid), .brg_done(brg_done),
  .gnt_cpu(gnt_cpu), .gnt_brg(gnt_brg), .gnt_sneak(gnt_sneak)
);

// File: tb/sim_dual_rate_arbiter.sv
module sim_dual_rate_arbiter;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h4000;
  localparam logic [AW-1:0] MASK = 16'hC000;
  localparam logic [AW-1:0] A_DDR = 16'h4123;
  localparam logic [AW-1:0] A_IO  = 16'h8123;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_done = 0, sys_active = 0, brg_valid = 0, brg_done = 0, cfg_we = 0;
  logic [1:0] cpu_prio = 0, sys_prio = 0;
  logic [AW-1:0] cpu_addr = 0;
  logic [3:0] cfg_wdata = 0;
  logic gnt_cpu, gnt_brg, gnt_sneak;
  int checks = 0, errors = 0, cycles = 0;
  bit done_flag = 0;

  always #5 clk = !clk;

  dual_rate_arbiter #(.AW(AW), .DDR_BASE(BASE), .DDR_MASK(MASK)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_prio(cpu_prio),
    .cpu_addr(cpu_addr), .cpu_done(cpu_done), .sys_active(sys_active),
    .sys_prio(sys_prio), .brg_valid(brg_valid), .brg_done(brg_done),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .gnt_cpu(gnt_cpu), .gnt_brg(gnt_brg), .gnt_sneak(gnt_sneak)
  );

  // {cpu_req, cpu_prio, ddr, sys_active, sys_prio, brg_valid, expect}
  // expect: 0 none, 1 cpu, 2 bridge, 3 sneak
  localparam logic [9:0] VEC [13] = '{
    {1'b1, 2'd1, 1'b1, 1'b0, 2'd0, 1'b0, 2'd1},  // R1 quiet buses
    {1'b1, 2'd3, 1'b1, 1'b1, 2'd1, 1'b1, 2'd1},  // R2 cpu higher
    {1'b1, 2'd0, 1'b1, 1'b1, 2'd2, 1'b1, 2'd2},  // R3 cpu lower
    {1'b1, 2'd2, 1'b1, 1'b1, 2'd2, 1'b1, 2'd2},  // R4 equal, bridge first
    {1'b1, 2'd2, 1'b1, 1'b1, 2'd2, 1'b1, 2'd1},  // R4 equal, cpu next
    {1'b1, 2'd1, 1'b1, 1'b1, 2'd2, 1'b0, 2'd3},  // R6 sneak at level 2
    {1'b1, 2'd1, 1'b1, 1'b1, 2'd1, 1'b0, 2'd0},  // R7 level 1 disabled
    {1'b1, 2'd0, 1'b0, 1'b1, 2'd2, 1'b0, 2'd0},  // R8 outside DDR
    {1'b1, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 2'd3},  // R6 sneak at level 0
    {1'b1, 2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 2'd2},  // R9 turn untouched: bridge
    {1'b1, 2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 2'd1},  // R4 then cpu
    {1'b1, 2'd2, 1'b1, 1'b1, 2'd1, 1'b0, 2'd1},  // R2 higher, bridge not ready
    {1'b1, 2'd3, 1'b1, 1'b1, 2'd3, 1'b0, 2'd0}   // R7 level 3 disabled
  };

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gcode();
    if (gnt_cpu && gnt_sneak) return 3;
    if (gnt_cpu) return 1;
    if (gnt_brg) return 2;
    return 0;
  endfunction

  task automatic release_all();
    cpu_req = 0; brg_valid = 0; sys_active = 0;
    cpu_done = gnt_cpu; brg_done = gnt_brg;
    @(negedge clk);
    cpu_done = 0; brg_done = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(gcode() == 0, "R5 reset idle", gcode(), 0);

    // R10: enable register is zero after reset, so no sneak at level 0
    cpu_req = 1; cpu_prio = 0; cpu_addr = A_DDR; sys_active = 1; sys_prio = 0;
    @(negedge clk);
    chk(gcode() == 0, "R10 reset enables clear", gcode(), 0);
    release_all();

    // R10: write 4'b0101
    cfg_we = 1; cfg_wdata = 4'b0101;
    @(negedge clk);
    cfg_we = 0;

    foreach (VEC[i]) begin
      logic [9:0] v;
      v = VEC[i];
      @(negedge clk);
      cpu_req = v[9]; cpu_prio = v[8:7]; cpu_addr = v[6] ? A_DDR : A_IO;
      sys_active = v[5]; sys_prio = v[4:3]; brg_valid = v[2];
      @(negedge clk);
      chk(gcode() == int'(v[1:0]), $sformatf("vector %0d R1-table", i), gcode(), int'(v[1:0]));
      release_all();
      chk(gcode() == 0, "R5 released after done", gcode(), 0);
    end

    // R5: grant held while done is low, despite a higher bridge request
    @(negedge clk);
    cpu_req = 1; cpu_prio = 0; cpu_addr = A_DDR; sys_active = 0; brg_valid = 0;
    @(negedge clk);
    chk(gcode() == 1, "R5 cpu granted", gcode(), 1);
    brg_valid = 1; sys_active = 1; sys_prio = 3;
    repeat (3) @(negedge clk);
    chk(gcode() == 1, "R5 grant held", gcode(), 1);
    cpu_req = 0; cpu_done = 1;
    @(negedge clk);
    cpu_done = 0;
    chk(gcode() == 0, "R5 idle gap after done", gcode(), 0);
    @(negedge clk);
    chk(gcode() == 2, "R5 bridge after gap", gcode(), 2);
    release_all();

    // R10: reset clears enables again
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    cpu_req = 1; cpu_prio = 1; cpu_addr = A_DDR; sys_active = 1; sys_prio = 2;
    @(negedge clk);
    chk(gcode() == 0, "R10 enables cleared by reset", gcode(), 0);
    release_all();

    finish_up();
  end
endmodule